// File: doc/BRIEF.md
# Gapped Transport-Stream Byte-Clock Generator

This block produces a byte-rate strobe for a transport stream, working entirely inside one fast processing-clock domain. A phase accumulator adds a static frequency control word on every processing clock. Each time the accumulator overflows, a new byte period begins. As a result, every byte period is a whole number of processing-clock cycles: either k or k+1, where k is 2^ACC_W divided by the control word, rounded down. The mix of short and long periods makes the long-run average rate match the programmed rate.

The strobes are grouped into frames of 204 slots. The first 188 slots of each frame are data slots. In each of them, the block samples the byte input and raises a valid flag. The remaining 16 slots form a gap, in which the flag is low and the data output is zero. Any logic that consumes bytes at the transport rate can use the strobe as a clock enable.

Top module: `ts_byteclk_gen`

## Requirements
- R1: `bclk_stb` is high for exactly one processing-clock cycle per byte period. When the top bit of `rate_word` is 0, two consecutive cycles never both carry a strobe.
- R2: Every interval between consecutive strobes lasts k or k+1 cycles, with k = floor(2^24 / `rate_word`) for the default 24-bit accumulator.
- R3: Over many periods, the average interval equals 2^24 / `rate_word`. The accumulated timing error stays below two cycles.
- R4: Slots are numbered 0 to 203 in strobe order. After slot 203 the numbering returns to 0, so a data slot always follows the last gap slot.
- R5: On the strobe of slots 0 to 187, `byte_vld` is 1. On the strobe of slots 188 to 203, `byte_vld` is 0.
- R6: In a data slot, `byte_out` takes the value that `byte_in` held at the clock edge that raises the strobe.
- R7: In a gap slot, `byte_out` is 0.
- R8: Between strobes, `byte_out` and `byte_vld` keep the values they took at the last strobe.
- R9: While `rst_n` is low at a clock edge, all outputs and the phase and slot state clear. The first strobe after release is slot 0 of a fresh frame, even if reset arrived mid-frame.
- R10: With `rate_word` equal to 0, no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_word | input | 24 | Static frequency control word (phase step per cycle) |
| byte_in | input | 8 | Byte to be taken in the current slot |
| bclk_stb | output | 1 | One-cycle byte-clock strobe |
| byte_vld | output | 1 | High for data slots, low for gap slots |
| byte_out | output | 8 | Byte of the current slot, zero in gap slots |

## Verification
The accumulator overflow is registered once, so the strobe, the valid flag and the captured byte all become visible one processing-clock edge after the cycle in which the overflow is computed. The captured byte is the `byte_in` value held just before that edge. The bench drives `byte_in` at falling edges and samples every output at the following falling edge, so the byte it expects on a strobe is the one it drove half a cycle before the capturing edge. Interval lengths are measured in falling edges between observed strobes. Slot numbers come from the bench's own count of strobes since reset release, so every frame boundary and gap is compared against a model that knows nothing of the design's counter.

// File: rtl/ts_bclk_pkg.sv
// Shared types for the gapped byte-clock generator.
// Assumes byte-wide transport data.
package ts_bclk_pkg;
    localparam int unsigned TS_BYTE_W = 8;

    typedef logic [TS_BYTE_W-1:0] ts_byte_t;

    // Registered content of one byte slot.
    typedef struct packed {
        logic     valid;
        ts_byte_t data;
    } ts_slot_out_t;
endpackage

// File: rtl/tsb_phase_acc.sv
// Phase accumulator of the byte-clock NCO.
// Adds the step word on every clock and reports the overflow as a combinational carry.
// Assumes the step word is held static outside of reset.
module tsb_phase_acc #(
    parameter int unsigned ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] step_i,
    output logic             wrap_o
);
    logic [ACC_W-1:0] phase_q;
    logic [ACC_W:0]   sum_w;

    // Widened sum so the overflow bit is kept.
    always_comb begin
        sum_w = {1'b0, phase_q} + {1'b0, step_i};
    end

    assign wrap_o = sum_w[ACC_W];

    // Advance the phase by one step every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= sum_w[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/tsb_slot_ctr.sv
// Frame slot counter.
// Holds the index of the slot that the next strobe will open, and flags whether that slot is a data slot.
// Assumes that advance pulses coincide with accumulator overflows.
module tsb_slot_ctr #(
    parameter int unsigned FRAME_SLOTS = 204,
    parameter int unsigned VALID_SLOTS = 188,
    localparam int unsigned SLOT_W     = $clog2(FRAME_SLOTS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    output logic data_slot_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);
    localparam logic [SLOT_W-1:0] GAP_FIRST = SLOT_W'(VALID_SLOTS);

    logic [SLOT_W-1:0] next_slot_q;

    // Slots below the gap boundary carry data.
    assign data_slot_o = (next_slot_q < GAP_FIRST);

    // Step to the following slot, wrapping at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_slot_q <= '0;
        end else if (adv_i) begin
            if (next_slot_q == LAST_SLOT) begin
                next_slot_q <= '0;
            end else begin
                next_slot_q <= next_slot_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tsb_out_stage.sv
// Output register stage.
// Raises the strobe for one cycle per overflow and captures the slot's flag and byte on that same edge.
// Gap slots output zero data.
module tsb_out_stage
    import ts_bclk_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wrap_i,
    input  logic         data_slot_i,
    input  ts_byte_t     byte_i,
    output logic         stb_o,
    output ts_slot_out_t slot_o
);
    ts_slot_out_t next_w;

    // Content for the slot that opens on this edge.
    always_comb begin
        next_w.valid = data_slot_i;
        next_w.data  = data_slot_i ? byte_i : '0;
    end

    // Strobe follows the overflow; the slot content is held between overflows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_o  <= 1'b0;
            slot_o <= '0;
        end else begin
            stb_o <= wrap_i;
            if (wrap_i) begin
                slot_o <= next_w;
            end
        end
    end
endmodule

// File: rtl/ts_byteclk_gen.sv
// Gapped transport-stream byte-clock generator (top).
// An NCO sets the byte period to k or k+1 clocks. Strobes are grouped into frames,
// and only the leading slots of each frame carry data.
// Assumes rate_word changes only while rst_n is low.
module ts_byteclk_gen
    import ts_bclk_pkg::*;
#(
    parameter int unsigned ACC_W       = 24,
    parameter int unsigned FRAME_SLOTS = 204,
    parameter int unsigned VALID_SLOTS = 188
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ACC_W-1:0]     rate_word,
    input  logic [TS_BYTE_W-1:0] byte_in,
    output logic                 bclk_stb,
    output logic                 byte_vld,
    output logic [TS_BYTE_W-1:0] byte_out
);
    logic         wrap_w;
    logic         data_slot_w;
    ts_slot_out_t slot_w;

    tsb_phase_acc #(
        .ACC_W (ACC_W)
    ) acc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (rate_word),
        .wrap_o (wrap_w)
    );

    tsb_slot_ctr #(
        .FRAME_SLOTS (FRAME_SLOTS),
        .VALID_SLOTS (VALID_SLOTS)
    ) slot_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_i       (wrap_w),
        .data_slot_o (data_slot_w)
    );

    tsb_out_stage out_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wrap_i      (wrap_w),
        .data_slot_i (data_slot_w),
        .byte_i      (byte_in),
        .stb_o       (bclk_stb),
        .slot_o      (slot_w)
    );

    assign byte_vld = slot_w.valid;
    assign byte_out = slot_w.data;
endmodule

// File: rtl/tsb_checker.sv
// Property checker for ts_byteclk_gen, attached by bind.
// Keeps its own slot count and interval counter, built from the output strobe only.
module tsb_checker #(
    parameter int unsigned ACC_W       = 24,
    parameter int unsigned FRAME_SLOTS = 204,
    parameter int unsigned VALID_SLOTS = 188,
    parameter int unsigned DATA_W      = 8,
    localparam int unsigned SLOT_W     = $clog2(FRAME_SLOTS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ACC_W-1:0]  rate_word,
    input logic              bclk_stb,
    input logic              byte_vld,
    input logic [DATA_W-1:0] byte_out
);
    logic [SLOT_W-1:0] cnt_slot_q;
    logic              seen_q;
    logic [31:0]       gap_q;
    logic [ACC_W:0]    k_w;

    // Expected short period for the current step word.
    assign k_w = (rate_word == '0) ? '0 : ({1'b1, {ACC_W{1'b0}}} / {1'b0, rate_word});

    // Count strobes into slots and measure cycles since the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_slot_q <= '0;
            seen_q     <= 1'b0;
            gap_q      <= 32'd1;
        end else if (bclk_stb) begin
            cnt_slot_q <= (cnt_slot_q == SLOT_W'(FRAME_SLOTS - 1)) ? '0 : cnt_slot_q + 1'b1;
            seen_q     <= 1'b1;
            gap_q      <= 32'd1;
        end else if (gap_q != 32'hFFFF_FFFF) begin
            gap_q <= gap_q + 32'd1;
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_stb && !rate_word[ACC_W-1]) |=> !bclk_stb); // R1

    AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_stb && seen_q && rate_word != '0) |->
        (gap_q >= 32'(k_w) && gap_q <= 32'(k_w) + 32'd1)); // R2

    AST_VALID_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_stb |-> (byte_vld == (cnt_slot_q < SLOT_W'(VALID_SLOTS)))); // R5

    AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_stb && !byte_vld) |-> (byte_out == '0)); // R7

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_stb |-> ($stable(byte_out) && $stable(byte_vld))); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!bclk_stb && !byte_vld && byte_out == '0)); // R9

    AST_NO_STROBE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_word == '0) |=> !bclk_stb); // R10
endmodule

bind ts_byteclk_gen tsb_checker #(
    .ACC_W       (ACC_W),
    .FRAME_SLOTS (FRAME_SLOTS),
    .VALID_SLOTS (VALID_SLOTS),
    .DATA_W      (ts_bclk_pkg::TS_BYTE_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_word (rate_word),
    .bclk_stb  (bclk_stb),
    .byte_vld  (byte_vld),
    .byte_out  (byte_out)
);

// File: tb/ts_byteclk_gen_tb_top.sv
// Directed bench for ts_byteclk_gen: one task per scenario, each checking its own results.
module ts_byteclk_gen_tb_top;
    localparam int FRAME = 204;
    localparam int VALID = 188;
    localparam longint ONE = 64'd1 << 24;
    localparam int WATCHDOG_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] rate_word = '0;
    logic [7:0]  byte_in = '0;
    logic        bclk_stb;
    logic        byte_vld;
    logic [7:0]  byte_out;

    int checks = 0;
    int errors = 0;
    int cyc_all = 0;

    always #2 clk = ~clk;

    ts_byteclk_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_word (rate_word),
        .byte_in   (byte_in),
        .bclk_stb  (bclk_stb),
        .byte_vld  (byte_vld),
        .byte_out  (byte_out)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Hold reset for a few cycles with a new step word, then check that the outputs are cleared (R9).
    task automatic do_reset(input logic [23:0] f);
        @(negedge clk);
        rst_n     = 1'b0;
        rate_word = f;
        repeat (3) @(negedge clk);
        chk(bclk_stb == 1'b0 && byte_vld == 1'b0 && byte_out == 8'h00, "R9 reset clear",
            {bclk_stb, byte_vld, byte_out}, 0);
        rst_n = 1'b1;
    endtask

    // Run nslots strobes at step f and check intervals, the slot pattern, data capture and hold.
    task automatic run_case(input logic [23:0] f, input int nslots);
        longint k = ONE / longint'(f);
        longint first_c = 0, last_c = 0, c = 0, span, err;
        int  n = 0;
        bit  prev_stb = 1'b0;
        bit  prev_vld = 1'b0;
        logic [7:0] held_d = '0;
        bit  held_v = 1'b0;
        int  vld_in_frame = 0;
        do_reset(f);
        while (n < nslots && c < 40000) begin
            @(negedge clk);
            c++;
            if (bclk_stb) begin
                int slot = n % FRAME;
                bit expv = (slot < VALID);
                if (n == 0) begin
                    chk(byte_vld == 1'b1, "R9 first strobe is slot 0", byte_vld, 1);
                    first_c = c;
                end else begin
                    chk(c - last_c == k || c - last_c == k + 1, "R2 interval", c - last_c, k);
                    if (k >= 2) chk(!prev_stb, "R1 single-cycle strobe", prev_stb, 0);
                end
                if (slot == 0 && n > 0) begin
                    chk(byte_vld && !prev_vld, "R4 wrap to data slot", {prev_vld, byte_vld}, 1);
                    chk(vld_in_frame == VALID, "R5 data slots per frame", vld_in_frame, VALID);
                    vld_in_frame = 0;
                end
                chk(byte_vld == expv, "R5 valid pattern", byte_vld, expv);
                if (expv) begin
                    chk(byte_out == byte_in, "R6 captured byte", byte_out, byte_in);
                    vld_in_frame++;
                end else begin
                    chk(byte_out == 8'h00, "R7 gap byte zero", byte_out, 0);
                end
                prev_vld = byte_vld;
                held_d   = byte_out;
                held_v   = byte_vld;
                last_c   = c;
                n++;
            end else if (n > 0) begin
                chk(byte_out == held_d && byte_vld == held_v, "R8 hold between strobes",
                    {byte_vld, byte_out}, {held_v, held_d});
            end else begin
                chk(byte_out == 8'h00 && !byte_vld, "R9 idle before first strobe", byte_out, 0);
            end
            prev_stb = bclk_stb;
            byte_in  = 8'(c * 29 + 7);
        end
        chk(n == nslots, "R2 strobe count reached", n, nslots);
        if (n > 1) begin
            span = last_c - first_c;
            err  = span * longint'(f) - longint'(n - 1) * ONE;
            if (err < 0) err = -err;
            chk(err < 2 * longint'(f), "R3 average rate", err, 0);
        end
    endtask

    // With a zero step word no strobe may appear (R10).
    task automatic run_zero();
        int seen = 0;
        do_reset(24'd0);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (bclk_stb) seen++;
            byte_in = 8'(i);
        end
        chk(seen == 0, "R10 no strobe at zero rate", seen, 0);
        chk(byte_out == 8'h00 && !byte_vld, "R10 outputs idle", byte_out, 0);
    endtask

    // Reset mid-frame, then confirm that the frame restarts at slot 0 (R9).
    task automatic run_midreset();
        run_case(24'd3901612, 120);
        run_case(24'd3901612, FRAME + 30);
    endtask

    initial begin
        run_case(24'd4194304, 3 * FRAME);   // exact period of 4
        run_case(24'd3901612, 3 * FRAME);   // periods of 4 and 5
        run_case(24'd2396745, 2 * FRAME);   // periods of 7 and 8
        run_zero();
        run_midreset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: an expired run counts as one failed check.
    always @(posedge clk) begin
        cyc_all <= cyc_all + 1;
        if (cyc_all == WATCHDOG_CYC) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_all, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule